// File: doc/BRIEF.md
# Iterative Integer Divider with Exception Flags

This block divides a 32-bit dividend by a divisor over many clock cycles and returns both a quotient and a remainder. It covers four operation kinds, chosen by a two-bit select. The divisor is either the full word or only its low halfword, and the division is signed or unsigned. Besides the two results, the block keeps a zero flag, a sign flag and an overflow flag. The surrounding pipeline reads these flags after each operation.

A request is made by pulsing `start` while `busy` is low. A normal division runs one restoring shift-subtract step per clock and then one correction step that fixes the signs of the results. At the end `done` pulses together with separate write enables for the quotient and the remainder destinations. Two operand patterns skip the loop. A zero divisor only raises the overflow flag. Signed division of the most negative word by minus one writes a fixed answer and a fixed flag pattern. Both special cases finish in a single cycle.

Top module: `divFlagUnit`

## Requirements
- R1: A `start` seen while `busy` is low is accepted, and `busy` is high in the following cycle until the result is delivered.
- R2: A normal division raises `done` on the 33rd rising edge after the accepting edge. A zero divisor or the signed overflow pattern raises `done` on the first edge after it. `done` lasts one cycle.
- R3: Select 2'b00 (unsigned word) yields the unsigned quotient and remainder of the two 32-bit operands.
- R4: Select 2'b01 (signed word) truncates the quotient toward zero. The remainder takes the sign of the dividend.
- R5: Select 2'b11 (signed halfword) uses the sign-extended bits 15:0 of `divisor` as the divisor, with the full 32-bit dividend.
- R6: Select 2'b10 (unsigned halfword) uses the zero-extended bits 15:0 of `divisor` as the divisor.
- R7: On normal completion both `quoWe` and `remWe` pulse with `done`. `flagOv` is cleared, `flagZ` is set exactly when the quotient is zero, and `flagS` equals quotient bit 31.
- R8: When the effective divisor is zero, `flagOv` is set and `flagZ`/`flagS` keep their values. Neither write enable pulses, and `quotient`/`remainder` keep their previous values.
- R9: For a signed select with dividend 0x80000000 and effective divisor of all ones, the quotient is 0x80000000 and the remainder is 0. Both are written, `flagOv` and `flagS` are set, and `flagZ` is cleared.
- R10: While `busy` is high, a new `start` and changes to the operands or the select have no effect on the running division, its result or its completion time.
- R11: After reset, `busy`, `done`, both write enables, all flags and both result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a division when idle |
| opSel | input | 2 | Bit 0: signed; bit 1: halfword divisor |
| dividend | input | 32 | Dividend, sampled on the accepting edge |
| divisor | input | 32 | Divisor register value, sampled on the accepting edge |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse |
| quoWe | output | 1 | Quotient destination write enable |
| remWe | output | 1 | Remainder destination write enable |
| quotient | output | 32 | Quotient result |
| remainder | output | 32 | Remainder result |
| flagZ | output | 1 | Zero flag |
| flagS | output | 1 | Sign flag |
| flagOv | output | 1 | Overflow flag |

## Verification
The hardest behaviour to observe is that a zero divisor leaves the zero and sign flags unchanged. The flags only show a difference if they held distinct values beforehand. The stimulus therefore first runs a division that leaves the sign flag set, then issues a zero divisor. It then runs a division that leaves the zero flag set and issues a halfword zero divisor whose upper sixteen bits are nonzero. After each zero-divisor case the bench compares the flags and result outputs with their values from before. To exercise the busy window, the bench changes the operands and pulses `start` in the middle of a running loop, then checks both the completion cycle and the original quotient.

// File: rtl/divPkg.sv
package divPkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RUN,
    ST_FIX,
    ST_ZERO,
    ST_OVF
  } divStateT;

  typedef struct packed {
    logic load;
    logic step;
    logic finish;
    logic ovfFix;
    logic zeroFix;
  } divStrobeT;
endpackage

// File: rtl/divCtrl.sv
module divCtrl
  import divPkg::*;
#(
  parameter int W = 32
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      isZeroDiv,
  input  logic      isOvf,
  output divStrobeT strb,
  output logic      busy,
  output logic      done,
  output logic      quoWe,
  output logic      remWe
);
  localparam int CNT_W = $clog2(W);
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(W - 1);

  divStateT state, nextState;
  logic [CNT_W-1:0] stepCnt;

  always_comb begin
    strb = '0;
    nextState = state;
    case (state)
      ST_IDLE: if (start) begin
        strb.load = 1'b1;
        if (isZeroDiv)  nextState = ST_ZERO;
        else if (isOvf) nextState = ST_OVF;
        else            nextState = ST_RUN;
      end
      ST_RUN: begin
        strb.step = 1'b1;
        if (stepCnt == LAST_STEP) nextState = ST_FIX;
      end
      ST_FIX: begin
        strb.finish = 1'b1;
        nextState = ST_IDLE;
      end
      ST_ZERO: begin
        strb.zeroFix = 1'b1;
        nextState = ST_IDLE;
      end
      ST_OVF: begin
        strb.ovfFix = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
      done    <= 1'b0;
      quoWe   <= 1'b0;
      remWe   <= 1'b0;
    end else begin
      state   <= nextState;
      stepCnt <= strb.step ? stepCnt + 1'b1 : '0;
      done    <= strb.finish | strb.ovfFix | strb.zeroFix;
      quoWe   <= strb.finish | strb.ovfFix;
      remWe   <= strb.finish | strb.ovfFix;
    end
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/divPath.sv
module divPath
  import divPkg::*;
#(
  parameter int W = 32,
  parameter int H = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  divStrobeT    strb,
  input  logic [1:0]   opSel,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         isZeroDiv,
  output logic         isOvf,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic         flagZ,
  output logic         flagS,
  output logic         flagOv
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  logic         isSigned;
  logic [W-1:0] divEff, aMag, bMag, bMagReg, quoReg, remAcc;
  logic [W:0]   shifted, trial;
  logic         negQ, negR;
  logic [W-1:0] qFinal, rFinal;

  always_comb begin
    isSigned = opSel[0];
    if (opSel[1])
      divEff = isSigned ? {{(W-H){divisor[H-1]}}, divisor[H-1:0]}
                        : {{(W-H){1'b0}}, divisor[H-1:0]};
    else
      divEff = divisor;
    isZeroDiv = (divEff == '0);
    isOvf     = isSigned && (dividend == MOST_NEG) && (divEff == '1);
    aMag = (isSigned && dividend[W-1]) ? -dividend : dividend;
    bMag = (isSigned && divEff[W-1])   ? -divEff   : divEff;
    shifted = {remAcc, quoReg[W-1]};
    trial   = shifted - {1'b0, bMagReg};
    qFinal  = negQ ? -quoReg : quoReg;
    rFinal  = negR ? -remAcc : remAcc;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      quoReg    <= '0;
      remAcc    <= '0;
      bMagReg   <= '0;
      negQ      <= 1'b0;
      negR      <= 1'b0;
      quotient  <= '0;
      remainder <= '0;
      flagZ     <= 1'b0;
      flagS     <= 1'b0;
      flagOv    <= 1'b0;
    end else begin
      if (strb.load) begin
        quoReg  <= aMag;
        remAcc  <= '0;
        bMagReg <= bMag;
        negQ    <= isSigned && (dividend[W-1] ^ divEff[W-1]);
        negR    <= isSigned && dividend[W-1];
      end
      if (strb.step) begin
        if (!trial[W]) begin
          remAcc <= trial[W-1:0];
          quoReg <= {quoReg[W-2:0], 1'b1};
        end else begin
          remAcc <= shifted[W-1:0];
          quoReg <= {quoReg[W-2:0], 1'b0};
        end
      end
      if (strb.finish) begin
        quotient  <= qFinal;
        remainder <= rFinal;
        flagZ     <= (qFinal == '0);
        flagS     <= qFinal[W-1];
        flagOv    <= 1'b0;
      end
      if (strb.ovfFix) begin
        quotient  <= MOST_NEG;
        remainder <= '0;
        flagZ     <= 1'b0;
        flagS     <= 1'b1;
        flagOv    <= 1'b1;
      end
      if (strb.zeroFix) flagOv <= 1'b1;
    end
  end
endmodule

// File: rtl/divFlagUnit.sv
module divFlagUnit
  import divPkg::*;
#(
  parameter int W = 32,
  parameter int H = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [1:0]   opSel,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic         quoWe,
  output logic         remWe,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic         flagZ,
  output logic         flagS,
  output logic         flagOv
);
  divStrobeT strb;
  logic isZeroDiv, isOvf;

  divCtrl #(.W(W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .isZeroDiv(isZeroDiv), .isOvf(isOvf), .strb(strb),
    .busy(busy), .done(done), .quoWe(quoWe), .remWe(remWe)
  );

  divPath #(.W(W), .H(H)) u_path (
    .clk(clk), .rstN(rstN), .strb(strb), .opSel(opSel),
    .dividend(dividend), .divisor(divisor),
    .isZeroDiv(isZeroDiv), .isOvf(isOvf),
    .quotient(quotient), .remainder(remainder),
    .flagZ(flagZ), .flagS(flagS), .flagOv(flagOv)
  );
endmodule

// File: rtl/divFlagUnitChk.sv
module divFlagUnitChk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rstN,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic         quoWe,
  input logic         remWe,
  input logic [W-1:0] quotient,
  input logic [W-1:0] remainder,
  input logic         flagZ,
  input logic         flagS,
  input logic         flagOv
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  // R1
  start_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    start && !busy |=> busy);

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7
  we_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    quoWe |-> done && remWe);

  // R7
  norm_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    quoWe && !flagOv |-> flagZ == (quotient == '0) && flagS == quotient[W-1]);

  // R8
  zero_div_chk: assert property (@(posedge clk) disable iff (!rstN)
    done && !quoWe |-> !remWe && flagOv && $stable(flagZ) && $stable(flagS)
                       && $stable(quotient) && $stable(remainder));

  // R9
  ovf_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    quoWe && flagOv |-> quotient == MOST_NEG && remainder == '0 && flagS && !flagZ);
endmodule

bind divFlagUnit divFlagUnitChk #(.W(W)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .quoWe(quoWe), .remWe(remWe), .quotient(quotient), .remainder(remainder),
  .flagZ(flagZ), .flagS(flagS), .flagOv(flagOv)
);

// File: tb/divFlagUnit_tb.sv
`timescale 1ns/1ps
module divFlagUnit_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [1:0] opSel = 2'b00;
  logic [31:0] dividend = '0, divisor = '0;
  logic busy, done, quoWe, remWe, flagZ, flagS, flagOv;
  logic [31:0] quotient, remainder;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  divFlagUnit u_dut (
    .clk(clk), .rstN(rstN), .start(start), .opSel(opSel),
    .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
    .quoWe(quoWe), .remWe(remWe), .quotient(quotient), .remainder(remainder),
    .flagZ(flagZ), .flagS(flagS), .flagOv(flagOv)
  );

  // {opSel, dividend, divisor, quotient, remainder}
  localparam int NV = 12;
  localparam logic [129:0] VEC [NV] = '{
    {2'b00, 32'd100,        32'd7,          32'd14,         32'd2},
    {2'b00, 32'hFFFFFFFF,   32'd1,          32'hFFFFFFFF,   32'd0},
    {2'b00, 32'd5,          32'd9,          32'd0,          32'd5},
    {2'b01, 32'hFFFFFFF9,   32'd2,          32'hFFFFFFFD,   32'hFFFFFFFF},
    {2'b01, 32'd7,          32'hFFFFFFFE,   32'hFFFFFFFD,   32'd1},
    {2'b01, 32'hFFFFFFF9,   32'hFFFFFFFE,   32'd3,          32'hFFFFFFFF},
    {2'b11, 32'd1000,       32'h1234FFF6,   32'hFFFFFF9C,   32'd0},
    {2'b10, 32'd1001,       32'hABCD0019,   32'd40,         32'd1},
    {2'b11, 32'h80000000,   32'h00000002,   32'hC0000000,   32'd0},
    {2'b01, 32'h80000000,   32'd1,          32'h80000000,   32'd0},
    {2'b00, 32'h80000000,   32'hFFFFFFFF,   32'd0,          32'h80000000},
    {2'b10, 32'h12345678,   32'h0001FFFF,   32'h00001234,   32'h000068AC}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Runs one operation, returns edges from accepting edge to done.
  task automatic runOp(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                       output int lat, output logic qwe, output logic rwe);
    @(negedge clk);
    opSel = op; dividend = a; divisor = b; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    if (busy !== 1'b1) check("R1 busy after accept", {31'd0, busy}, 32'd1);
    do begin
      @(posedge clk); lat++; @(negedge clk);
    end while (!done && lat < 100);
    qwe = quoWe; rwe = remWe;
  endtask

  task automatic checkNormal(input string tag, input logic [31:0] q, input logic [31:0] r,
                             input int lat, input logic qwe, input logic rwe);
    check({tag, " quotient"}, quotient, q);
    check({tag, " remainder"}, remainder, r);
    check("R2 normal latency", lat, 33);
    check("R7 write enables", {30'd0, qwe, rwe}, 32'd3);
    check("R7 flags {Z,S,OV}", {29'd0, flagZ, flagS, flagOv}, {29'd0, q == 0, q[31], 1'b0});
  endtask

  initial begin
    #(4.0 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int lat;
    logic qwe, rwe;
    logic [31:0] oldQ, oldR;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    check("R11 reset outputs", {25'd0, busy, done, quoWe, remWe, flagZ, flagS, flagOv}, 32'd0);
    check("R11 reset quotient", quotient, 32'd0);
    check("R11 reset remainder", remainder, 32'd0);
    rstN = 1'b1;

    // R3 R4 R5 R6 table of vectors
    for (int i = 0; i < NV; i++) begin
      logic [1:0] op;
      string tag;
      op = VEC[i][129:128];
      tag = (op == 2'b00) ? "R3" : (op == 2'b01) ? "R4" : (op == 2'b11) ? "R5" : "R6";
      runOp(op, VEC[i][127:96], VEC[i][95:64], lat, qwe, rwe);
      checkNormal(tag, VEC[i][63:32], VEC[i][31:0], lat, qwe, rwe);
    end

    // R3 R4 random operands against a language-level reference
    for (int i = 0; i < 24; i++) begin
      logic [31:0] a, b, q, r;
      logic sgn;
      a = $urandom; b = $urandom >> (i % 31);
      if (b == 0) b = 32'd3;
      sgn = i[0];
      if (sgn && a == 32'h80000000 && b == 32'hFFFFFFFF) b = 32'd5;
      if (sgn) begin
        q = $signed(a) / $signed(b);
        r = $signed(a) % $signed(b);
      end else begin
        q = a / b; r = a % b;
      end
      runOp({1'b0, sgn}, a, b, lat, qwe, rwe);
      checkNormal(sgn ? "R4 random" : "R3 random", q, r, lat, qwe, rwe);
    end

    // R8 zero divisor after a result with S=1, Z=0
    runOp(2'b01, 32'hFFFFFFF9, 32'd2, lat, qwe, rwe);
    oldQ = quotient; oldR = remainder;
    runOp(2'b01, 32'd1234, 32'd0, lat, qwe, rwe);
    check("R2 zero-divisor latency", lat, 1);
    check("R8 no write enables", {30'd0, qwe, rwe}, 32'd0);
    check("R8 flags {Z,S,OV}", {29'd0, flagZ, flagS, flagOv}, 32'b011);
    check("R8 quotient kept", quotient, oldQ);
    check("R8 remainder kept", remainder, oldR);

    // R8 halfword zero divisor after a result with Z=1, S=0
    runOp(2'b00, 32'd5, 32'd9, lat, qwe, rwe);
    runOp(2'b11, 32'd77, 32'hFFFF0000, lat, qwe, rwe);
    check("R8 half zero no write", {30'd0, qwe, rwe}, 32'd0);
    check("R8 half zero flags {Z,S,OV}", {29'd0, flagZ, flagS, flagOv}, 32'b101);
    check("R8 half zero quotient kept", quotient, 32'd0);
    check("R8 half zero remainder kept", remainder, 32'd5);

    // R9 signed word overflow
    runOp(2'b01, 32'h80000000, 32'hFFFFFFFF, lat, qwe, rwe);
    check("R2 overflow latency", lat, 1);
    check("R9 write enables", {30'd0, qwe, rwe}, 32'd3);
    check("R9 quotient", quotient, 32'h80000000);
    check("R9 remainder", remainder, 32'd0);
    check("R9 flags {Z,S,OV}", {29'd0, flagZ, flagS, flagOv}, 32'b011);

    // R9 signed halfword overflow, divisor low half 0xFFFF
    runOp(2'b01, 32'd4, 32'd2, lat, qwe, rwe);
    runOp(2'b11, 32'h80000000, 32'h0000FFFF, lat, qwe, rwe);
    check("R9 half quotient", quotient, 32'h80000000);
    check("R9 half remainder", remainder, 32'd0);
    check("R9 half flags {Z,S,OV}", {29'd0, flagZ, flagS, flagOv}, 32'b011);

    // R7 overflow flag cleared by the next normal division
    runOp(2'b00, 32'd9, 32'd3, lat, qwe, rwe);
    checkNormal("R7 after overflow", 32'd3, 32'd0, lat, qwe, rwe);

    // R10 new start and operand changes while busy are ignored
    @(negedge clk);
    opSel = 2'b00; dividend = 32'd1000; divisor = 32'd10; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    do begin
      @(posedge clk); lat++; @(negedge clk);
      if (lat == 5) begin
        start = 1'b1; opSel = 2'b01; dividend = 32'hFFFF0000; divisor = 32'd0;
      end
      if (lat == 7) start = 1'b0;
    end while (!done && lat < 100);
    check("R10 latency unchanged", lat, 33);
    check("R10 quotient", quotient, 32'd100);
    check("R10 remainder", remainder, 32'd0);
    check("R10 flags {Z,S,OV}", {29'd0, flagZ, flagS, flagOv}, 32'd0);
    @(negedge clk);
    check("R2 done one cycle", {31'd0, done}, 32'd0);
    check("R1 idle after done", {31'd0, busy}, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule